// File: doc/BRIEF.md
# Three-Word Accumulator Shift Chain

This block keeps a three-word accumulator made of an 8-bit extension word and two 32-bit words, high and low. It offers two word-granular moves for an integer pipeline. A pop hands the low word back to the caller and moves every word one place down toward the low end, with zero entering the extension word. A push moves every word one place up toward the extension end and places a new 32-bit value in the low word.

Each move takes effect on one clock edge while the valid strobe is high. The popped value appears on a registered read port in the following cycle. A parallel load port writes all three words at once, so a multiply unit can share the chain and deposit a wide product into it. The present contents are always visible on three observation outputs. Register-file writeback and hazard interlocks belong to the surrounding pipeline.

Top module: `acc_shift_chain`

## Requirements
- R1: While `rst_n` is low at a clock edge, the extension, high, low and read-data registers all become zero.
- R2: A pop is `op_valid`=1 with `op_code`=0 and `load_en`=0. After the edge that accepts it, `rd_data` equals the low word as it was before that edge.
- R3: On an accepted pop, the low word takes the old high word, the high word takes the old extension word zero-extended to 32 bits, and the extension word becomes zero.
- R4: A push is `op_valid`=1 with `op_code`=1 and `load_en`=0. On a push, the extension word takes bits [7:0] of the old high word, the high word takes the old low word, and the low word takes `wr_data`.
- R5: When `op_valid` and `load_en` are both low, none of the three words changes, whatever `op_code` and `wr_data` hold.
- R6: `rd_data` changes only on an accepted pop. Pushes, idle cycles and parallel loads leave it unchanged.
- R7: When `load_en` is high, the extension, high and low words take `load_ext`, `load_hi` and `load_lo` on that edge.
- R8: A parallel load has priority over a move in the same cycle. The move is dropped and does not update `rd_data`.
- R9: A push followed directly by a pop returns the pushed value and restores the low word. The high word comes back holding only bits [7:0] of its value before the push, and the extension word is zero.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Synchronous reset, active low |
| op_valid | input | 1 | Move request strobe |
| op_code | input | 1 | 0 = pop (read), 1 = push (write) |
| wr_data | input | 32 | Word that a push places in the low word |
| load_en | input | 1 | Parallel load of all three words |
| load_ext | input | 8 | Parallel load value, extension word |
| load_hi | input | 32 | Parallel load value, high word |
| load_lo | input | 32 | Parallel load value, low word |
| rd_data | output | 32 | Registered result of the last pop |
| ext_out | output | 8 | Present extension word |
| hi_out | output | 32 | Present high word |
| lo_out | output | 32 | Present low word |

## Verification
Pushes are given high words whose upper bits are set. A design that failed to truncate to eight bits, or that took the wrong slice, would show the wrong extension value after the push and the wrong high value after the next pop. The bench drains the chain with more pops than there are words, which catches a design that recirculates the extension word instead of clearing it. Idle cycles carry junk on the data inputs and a push opcode, which exposes a design that ignores the strobe. A parallel load is issued together with a pop, which exposes a design that lets the move win or that updates the read register for a dropped pop.

// File: rtl/acc_chain_pkg.sv
// Package: types shared by the accumulator shift chain.
// Assumes a single-bit operation code.
package acc_chain_pkg;

    // Move selector carried on op_code.
    typedef enum logic {
        OP_POP  = 1'b0,
        OP_PUSH = 1'b1
    } chain_op_e;

endpackage

// File: rtl/acc_chain_next.sv
// Next-state logic for the chain. Chooses between a parallel load, a pop and a
// push, and reports whether the words and the read register must update.
// Assumes EXT_W <= WORD_W. Purely combinational.
module acc_chain_next
    import acc_chain_pkg::*;
#(
    parameter int WORD_W = 32,
    parameter int EXT_W  = 8
) (
    input  logic              op_valid,
    input  logic              op_code,
    input  logic [WORD_W-1:0] wr_data,
    input  logic              load_en,
    input  logic [EXT_W-1:0]  load_ext,
    input  logic [WORD_W-1:0] load_hi,
    input  logic [WORD_W-1:0] load_lo,
    input  logic [EXT_W-1:0]  cur_ext,
    input  logic [WORD_W-1:0] cur_hi,
    input  logic [WORD_W-1:0] cur_lo,
    output logic [EXT_W-1:0]  nxt_ext,
    output logic [WORD_W-1:0] nxt_hi,
    output logic [WORD_W-1:0] nxt_lo,
    output logic              words_en,
    output logic              pop_fire
);

    localparam int PAD_W = WORD_W - EXT_W;

    logic [WORD_W-1:0] ext_wide;
    logic [EXT_W-1:0]  hi_narrow;
    chain_op_e         op;

    assign op = chain_op_e'(op_code);

    // Widen the extension word and narrow the high word; the shape depends on widths.
    generate
        if (PAD_W > 0) begin : g_pad
            assign ext_wide = {{PAD_W{1'b0}}, cur_ext};
        end else begin : g_nopad
            assign ext_wide = cur_ext[WORD_W-1:0];
        end
    endgenerate
    assign hi_narrow = cur_hi[EXT_W-1:0];

    // A move is accepted only when no parallel load claims the edge.
    assign words_en = load_en | op_valid;
    assign pop_fire = op_valid & ~load_en & (op == OP_POP);

    // Select the next value of every word.
    always_comb begin
        nxt_ext = cur_ext;
        nxt_hi  = cur_hi;
        nxt_lo  = cur_lo;
        if (load_en) begin
            nxt_ext = load_ext;
            nxt_hi  = load_hi;
            nxt_lo  = load_lo;
        end else if (op_valid) begin
            if (op == OP_POP) begin
                nxt_ext = '0;
                nxt_hi  = ext_wide;
                nxt_lo  = cur_hi;
            end else begin
                nxt_ext = hi_narrow;
                nxt_hi  = cur_lo;
                nxt_lo  = wr_data;
            end
        end
    end

endmodule

// File: rtl/acc_chain_store.sv
// Storage for the three accumulator words. Loads all of them together when
// enabled and clears them on synchronous active-low reset.
module acc_chain_store #(
    parameter int WORD_W = 32,
    parameter int EXT_W  = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              en,
    input  logic [EXT_W-1:0]  d_ext,
    input  logic [WORD_W-1:0] d_hi,
    input  logic [WORD_W-1:0] d_lo,
    output logic [EXT_W-1:0]  q_ext,
    output logic [WORD_W-1:0] q_hi,
    output logic [WORD_W-1:0] q_lo
);

    // Hold or update the chain.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            q_ext <= '0;
            q_hi  <= '0;
            q_lo  <= '0;
        end else if (en) begin
            q_ext <= d_ext;
            q_hi  <= d_hi;
            q_lo  <= d_lo;
        end
    end

endmodule

// File: rtl/acc_chain_rdreg.sv
// Read-result register. Captures the low word on an accepted pop and
// holds it otherwise.
module acc_chain_rdreg #(
    parameter int WORD_W = 32
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              capture,
    input  logic [WORD_W-1:0] lo_now,
    output logic [WORD_W-1:0] rd_q
);

    // Keep the value of the most recent pop.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            rd_q <= '0;
        end else if (capture) begin
            rd_q <= lo_now;
        end
    end

endmodule

// File: rtl/acc_shift_chain.sv
// Top of the accumulator shift chain: an extension word plus high and low
// words that shift by one word on a pop or a push. A parallel load port lets
// a multiply unit share the chain. Assumes EXT_W <= WORD_W. The caller
// handles writeback and hazards.
module acc_shift_chain #(
    parameter int WORD_W = 32,
    parameter int EXT_W  = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              op_valid,
    input  logic              op_code,
    input  logic [WORD_W-1:0] wr_data,
    input  logic              load_en,
    input  logic [EXT_W-1:0]  load_ext,
    input  logic [WORD_W-1:0] load_hi,
    input  logic [WORD_W-1:0] load_lo,
    output logic [WORD_W-1:0] rd_data,
    output logic [EXT_W-1:0]  ext_out,
    output logic [WORD_W-1:0] hi_out,
    output logic [WORD_W-1:0] lo_out
);

    logic [EXT_W-1:0]  nxt_ext;
    logic [WORD_W-1:0] nxt_hi;
    logic [WORD_W-1:0] nxt_lo;
    logic              words_en;
    logic              pop_fire;

    acc_chain_next #(.WORD_W(WORD_W), .EXT_W(EXT_W)) u_next (
        .op_valid (op_valid),
        .op_code  (op_code),
        .wr_data  (wr_data),
        .load_en  (load_en),
        .load_ext (load_ext),
        .load_hi  (load_hi),
        .load_lo  (load_lo),
        .cur_ext  (ext_out),
        .cur_hi   (hi_out),
        .cur_lo   (lo_out),
        .nxt_ext  (nxt_ext),
        .nxt_hi   (nxt_hi),
        .nxt_lo   (nxt_lo),
        .words_en (words_en),
        .pop_fire (pop_fire)
    );

    acc_chain_store #(.WORD_W(WORD_W), .EXT_W(EXT_W)) u_store (
        .clk   (clk),
        .rst_n (rst_n),
        .en    (words_en),
        .d_ext (nxt_ext),
        .d_hi  (nxt_hi),
        .d_lo  (nxt_lo),
        .q_ext (ext_out),
        .q_hi  (hi_out),
        .q_lo  (lo_out)
    );

    acc_chain_rdreg #(.WORD_W(WORD_W)) u_rd (
        .clk     (clk),
        .rst_n   (rst_n),
        .capture (pop_fire),
        .lo_now  (lo_out),
        .rd_q    (rd_data)
    );

endmodule

// File: rtl/acc_shift_chain_chk.sv
// Checker for the accumulator shift chain, attached to every instance of
// the top by the bind below. Observes ports only.
module acc_shift_chain_chk #(
    parameter int WORD_W = 32,
    parameter int EXT_W  = 8
) (
    input logic              clk,
    input logic              rst_n,
    input logic              op_valid,
    input logic              op_code,
    input logic [WORD_W-1:0] wr_data,
    input logic              load_en,
    input logic [EXT_W-1:0]  load_ext,
    input logic [WORD_W-1:0] load_hi,
    input logic [WORD_W-1:0] load_lo,
    input logic [WORD_W-1:0] rd_data,
    input logic [EXT_W-1:0]  ext_out,
    input logic [WORD_W-1:0] hi_out,
    input logic [WORD_W-1:0] lo_out
);

    logic is_pop;
    logic is_push;
    assign is_pop  = op_valid && !load_en && !op_code;
    assign is_push = op_valid && !load_en &&  op_code;

    p_reset_r1: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(rst_n) |-> (ext_out == '0 && hi_out == '0 && lo_out == '0 && rd_data == '0));

    p_pop_read_r2: assert property (@(posedge clk) disable iff (!rst_n)
        is_pop |=> rd_data == $past(lo_out));

    p_pop_shift_r3: assert property (@(posedge clk) disable iff (!rst_n)
        is_pop |=> (lo_out == $past(hi_out) && ext_out == '0 &&
                    hi_out == WORD_W'($past(ext_out))));

    p_push_shift_r4: assert property (@(posedge clk) disable iff (!rst_n)
        is_push |=> (lo_out == $past(wr_data) && hi_out == $past(lo_out) &&
                     ext_out == $past(hi_out[EXT_W-1:0])));

    p_idle_hold_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (!op_valid && !load_en) |=> ($stable(ext_out) && $stable(hi_out) && $stable(lo_out)));

    p_rd_hold_r6: assert property (@(posedge clk) disable iff (!rst_n)
        !is_pop |=> $stable(rd_data));

    p_load_r7: assert property (@(posedge clk) disable iff (!rst_n)
        load_en |=> (ext_out == $past(load_ext) && hi_out == $past(load_hi) &&
                     lo_out == $past(load_lo)));

endmodule

bind acc_shift_chain acc_shift_chain_chk #(.WORD_W(WORD_W), .EXT_W(EXT_W)) u_chk (.*);

// File: tb/acc_shift_chain_bench.sv
module acc_shift_chain_bench;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        op_valid = 1'b0;
    logic        op_code = 1'b0;
    logic [31:0] wr_data = '0;
    logic        load_en = 1'b0;
    logic [7:0]  load_ext = '0;
    logic [31:0] load_hi = '0;
    logic [31:0] load_lo = '0;
    logic [31:0] rd_data;
    logic [7:0]  ext_out;
    logic [31:0] hi_out;
    logic [31:0] lo_out;

    int  n_run  = 0;
    int  n_fail = 0;
    bit  done   = 1'b0;

    always #10 clk = ~clk;

    acc_shift_chain u_acc_shift_chain (.*);

    // Stimulus: {valid, op, wr_data}; expected: {ext, hi, lo, rd}
    localparam int NV = 10;
    localparam logic [33:0] STIM [NV] = '{
        {1'b1, 1'b1, 32'h11223344},
        {1'b1, 1'b1, 32'hAABBCCDD},
        {1'b1, 1'b1, 32'h01020304},
        {1'b0, 1'b1, 32'hFFFFFFFF},
        {1'b1, 1'b1, 32'h55667788},
        {1'b1, 1'b0, 32'hFFFFFFFF},
        {1'b1, 1'b0, 32'h00000000},
        {1'b1, 1'b0, 32'h00000000},
        {1'b1, 1'b0, 32'h00000000},
        {1'b1, 1'b1, 32'hCAFEF00D}
    };
    localparam logic [103:0] EXPV [NV] = '{
        {8'h00, 32'h00000000, 32'h11223344, 32'h00000000},
        {8'h00, 32'h11223344, 32'hAABBCCDD, 32'h00000000},
        {8'h44, 32'hAABBCCDD, 32'h01020304, 32'h00000000},
        {8'h44, 32'hAABBCCDD, 32'h01020304, 32'h00000000},
        {8'hDD, 32'h01020304, 32'h55667788, 32'h00000000},
        {8'h00, 32'h000000DD, 32'h01020304, 32'h55667788},
        {8'h00, 32'h00000000, 32'h000000DD, 32'h01020304},
        {8'h00, 32'h00000000, 32'h00000000, 32'h000000DD},
        {8'h00, 32'h00000000, 32'h00000000, 32'h00000000},
        {8'h00, 32'h00000000, 32'hCAFEF00D, 32'h00000000}
    };
    localparam string TAGS [NV] = '{
        "R4", "R4", "R4", "R5", "R4", "R2 R3", "R2 R3", "R2 R3", "R3", "R4 R6"
    };

    task automatic check(input string tag, input logic [7:0] e_ext,
                         input logic [31:0] e_hi, input logic [31:0] e_lo,
                         input logic [31:0] e_rd);
        n_run++;
        if (ext_out !== e_ext || hi_out !== e_hi || lo_out !== e_lo || rd_data !== e_rd) begin
            n_fail++;
            $display("FAIL %s: got ext=%h hi=%h lo=%h rd=%h, expected ext=%h hi=%h lo=%h rd=%h",
                     tag, ext_out, hi_out, lo_out, rd_data, e_ext, e_hi, e_lo, e_rd);
        end
    endtask

    // Drive inputs for one edge, then sample at the next falling edge.
    task automatic step(input logic v, input logic op, input logic [31:0] wd,
                        input logic ld, input logic [7:0] le,
                        input logic [31:0] lh, input logic [31:0] ll);
        op_valid = v; op_code = op; wr_data = wd;
        load_en = ld; load_ext = le; load_hi = lh; load_lo = ll;
        @(negedge clk);
        op_valid = 1'b0; load_en = 1'b0;
    endtask

    initial begin
        repeat (3) @(negedge clk);
        check("R1 reset", 8'h00, 32'h0, 32'h0, 32'h0);
        rst_n = 1'b1;
        @(negedge clk);

        for (int i = 0; i < NV; i++) begin
            step(STIM[i][33], STIM[i][32], STIM[i][31:0], 1'b0, 8'h0, 32'h0, 32'h0);
            check(TAGS[i], EXPV[i][103:96], EXPV[i][95:64], EXPV[i][63:32], EXPV[i][31:0]);
        end

        // R7: parallel load, then pop shows zero-extension of ext (R3)
        step(1'b0, 1'b0, 32'h0, 1'b1, 8'hA5, 32'h12345678, 32'h9ABCDEF0);
        check("R7 load", 8'hA5, 32'h12345678, 32'h9ABCDEF0, 32'h0);
        step(1'b1, 1'b0, 32'h0, 1'b0, 8'h0, 32'h0, 32'h0);
        check("R3 pop zero-extend", 8'h00, 32'h000000A5, 32'h12345678, 32'h9ABCDEF0);

        // R8: load together with a pop; the pop is dropped
        step(1'b1, 1'b0, 32'h0, 1'b1, 8'h3C, 32'h00000001, 32'h00000002);
        check("R8 load beats pop", 8'h3C, 32'h00000001, 32'h00000002, 32'h9ABCDEF0);

        // R5: idle with junk
        step(1'b0, 1'b1, 32'hDEADDEAD, 1'b0, 8'hFF, 32'hFFFFFFFF, 32'hFFFFFFFF);
        check("R5 idle", 8'h3C, 32'h00000001, 32'h00000002, 32'h9ABCDEF0);

        // R9: push then pop round trip with high upper bits set
        step(1'b0, 1'b0, 32'h0, 1'b1, 8'h77, 32'hDEADBEEF, 32'h0BADC0DE);
        check("R7 load2", 8'h77, 32'hDEADBEEF, 32'h0BADC0DE, 32'h9ABCDEF0);
        step(1'b1, 1'b1, 32'h13579BDF, 1'b0, 8'h0, 32'h0, 32'h0);
        check("R4 R6 push truncate", 8'hEF, 32'h0BADC0DE, 32'h13579BDF, 32'h9ABCDEF0);
        step(1'b1, 1'b0, 32'h0, 1'b0, 8'h0, 32'h0, 32'h0);
        check("R9 round trip", 8'h00, 32'h000000EF, 32'h0BADC0DE, 32'h13579BDF);

        // R1: reset in mid-run clears everything
        rst_n = 1'b0;
        @(negedge clk);
        check("R1 mid-run reset", 8'h00, 32'h0, 32'h0, 32'h0);
        rst_n = 1'b1;
        @(negedge clk);

        done = 1'b1;
        $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
        $finish;
    end

    initial begin
        repeat (5000) @(posedge clk);
        if (!done) begin
            n_run++;
            n_fail++;
            $display("FAIL watchdog: got timeout, expected completion");
            $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
            $finish;
        end
    end

endmodule